// File: doc/BRIEF.md
# Latch/Blank Pulse Width Discriminator

This block watches one asynchronous control line that carries two commands, told apart only by how long the line stays high. The line is first passed through a flop synchronizer. Each synchronized high pulse then gives a one-cycle latch strobe. The block counts the pulse's high time in system clock cycles. A pulse that stays high long enough is also treated as a blank command.

While blank is active, the surrounding chip holds every PWM output off. On the first cycle of blank the block issues a one-cycle global-reset request, which also clears the serial shift register. The analog pulse-width limits are replaced by two cycle-count parameters. `LATCH_MAX_CYCLES` is the longest pulse that must never blank. `BLANK_CYCLES` (which must be larger) sets the high time after which blank is certain. In this design, a pulse of H synchronized cycles blanks exactly when H > `BLANK_CYCLES`, which falls inside the freedom the two limits allow.

Top module: `ctl_pulse_classifier`

## Requirements
- R1: The raw input passes through two synchronizer flops. A rise on `ctl_i` that is set up before clock edge k makes `latch_o` high in the cycle after edge k+1, and not earlier.
- R2: Every synchronized high pulse of one or more cycles gives exactly one `latch_o` pulse. That pulse lasts one cycle and falls in the first synchronized high cycle.
- R3: A pulse of at most `LATCH_MAX_CYCLES` high cycles never raises `blank_o` or `reset_req_o`. With the chosen thresholds, this also holds for any pulse of at most `BLANK_CYCLES` cycles.
- R4: For a pulse of H > `BLANK_CYCLES` high cycles, `blank_o` first rises exactly `BLANK_CYCLES` cycles after that pulse's `latch_o`. It then stays high for H - `BLANK_CYCLES` cycles and drops in the same cycle as the synchronized input falls.
- R5: `reset_req_o` is a one-cycle pulse in the first cycle of each blank period, so it fires once per long pulse. It is never high without `blank_o`.
- R6: The high-time counter saturates and never wraps. A pulse far longer than `BLANK_CYCLES` keeps `blank_o` high without a gap until the input falls.
- R7: The counter clears whenever the synchronized input is low. Two pulses separated by a single low cycle each give their own latch strobe and their own blank timing.
- R8: While `rst_ni` is low, and after reset until the input rises, all three outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_i | input | 1 | Raw dual-function control line (asynchronous) |
| latch_o | output | 1 | One-cycle latch strobe on each synchronized rise |
| blank_o | output | 1 | High while a long pulse is in its blank period (forces PWM outputs off) |
| reset_req_o | output | 1 | One-cycle global-reset request at the start of blank |

## Verification
The assertions check these properties on every cycle:
- the latch strobe and the reset request never last more than one cycle;
- blank is only high while the synchronized line is high;
- the reset request only appears on a blank rise;
- the counter never passes its limit;
- blank never asserts before an independent checker count passes `LATCH_MAX_CYCLES`.

Some behaviour only the bench's pulse-length sweep can show:
- the exact latency through the synchronizer;
- the exact offset at which blank rises;
- the exact number of blank cycles for each pulse length;
- that back-to-back pulses each start a fresh measurement.

// File: rtl/ctl_pulse_pkg.sv
package ctl_pulse_pkg;
  typedef struct packed {
    logic latch;
    logic blank;
    logic reset_req;
  } ctl_evt_t;
endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q <= '0;
        else         ff_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q <= '0;
        else         ff_q <= {ff_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/high_timer.sv
module high_timer #(
  parameter int BLANK_CYCLES = 8,
  localparam int CNT_W = $clog2(BLANK_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic blank_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(BLANK_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  // counts prior high cycles; clears on low, holds at limit
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)             cnt_q <= '0;
    else if (!lvl_i)         cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;

  assign blank_o = lvl_i && (cnt_q == CNT_MAX);

  // R6
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX);

  // R7
  cnt_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lvl_i |=> cnt_q == '0);
endmodule

// File: rtl/evt_gen.sv
module evt_gen
  import ctl_pulse_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     lvl_i,
  input  logic     blank_i,
  output ctl_evt_t evt_o
);
  logic lvl_q, blank_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      lvl_q   <= 1'b0;
      blank_q <= 1'b0;
    end else begin
      lvl_q   <= lvl_i;
      blank_q <= blank_i;
    end

  assign evt_o.latch     = lvl_i & ~lvl_q;
  assign evt_o.blank     = blank_i;
  assign evt_o.reset_req = blank_i & ~blank_q;

  // R2
  latch_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o.latch |=> !evt_o.latch);

  // R5
  rst_req_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o.reset_req |=> !evt_o.reset_req);

  // R5
  rst_req_with_blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o.reset_req |-> evt_o.blank);

  // R4
  blank_needs_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o.blank |-> lvl_i);
endmodule

// File: rtl/ctl_pulse_classifier.sv
module ctl_pulse_classifier
  import ctl_pulse_pkg::*;
#(
  parameter int SYNC_STAGES      = 2,
  parameter int LATCH_MAX_CYCLES = 4,
  parameter int BLANK_CYCLES     = 8,
  localparam int CHK_W = $clog2(LATCH_MAX_CYCLES + 2)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ctl_i,
  output logic latch_o,
  output logic blank_o,
  output logic reset_req_o
);
  logic     ctl_s;
  logic     blank_w;
  ctl_evt_t evt;

  ctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ctl_i),
    .q_o   (ctl_s)
  );

  high_timer #(.BLANK_CYCLES(BLANK_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (ctl_s),
    .blank_o(blank_w)
  );

  evt_gen u_evt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (ctl_s),
    .blank_i(blank_w),
    .evt_o  (evt)
  );

  assign latch_o     = evt.latch;
  assign blank_o     = evt.blank;
  assign reset_req_o = evt.reset_req;

  // independent short-pulse window count for the no-blank guarantee
  localparam logic [CHK_W-1:0] CHK_MAX = CHK_W'(LATCH_MAX_CYCLES + 1);
  logic [CHK_W-1:0] chk_run_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                 chk_run_q <= '0;
    else if (!ctl_s)             chk_run_q <= '0;
    else if (chk_run_q != CHK_MAX) chk_run_q <= chk_run_q + 1'b1;

  // R3
  short_no_blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_o |-> chk_run_q > CHK_W'(LATCH_MAX_CYCLES));

  // R2
  latch_no_blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_o |-> !blank_o);
endmodule

// File: tb/ctl_pulse_classifier_test.sv
module ctl_pulse_classifier_test;
  localparam int L = 4;
  localparam int B = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl = 1'b0;
  logic latch, blank, rreq;

  always #2.5 clk = ~clk;

  ctl_pulse_classifier #(.SYNC_STAGES(2), .LATCH_MAX_CYCLES(L), .BLANK_CYCLES(B)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ctl_i(ctl),
    .latch_o(latch), .blank_o(blank), .reset_req_o(rreq)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // monitor totals, sampled away from the active edge
  int lat_tot = 0, blk_tot = 0, rst_tot = 0;
  int off = 0, last_blk_off = -1, blk_gap = 0;
  bit blank_prev = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (latch) begin lat_tot++; off = 0; end else off++;
      if (blank) blk_tot++;
      if (rreq) rst_tot++;
      if (blank && !blank_prev) last_blk_off = off;
      if (!blank && blank_prev && ctl) blk_gap++;
      blank_prev = blank;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse(int p, int gap);
    int l0, b0, r0;
    l0 = lat_tot; b0 = blk_tot; r0 = rst_tot;
    last_blk_off = -1;
    @(negedge clk) ctl = 1'b1;
    repeat (p) @(negedge clk);
    ctl = 1'b0;
    repeat (gap + 4) @(negedge clk);
    chk("R2 latch count", lat_tot - l0, 1);
    if (p <= B) begin
      chk("R3 no blank on short pulse", blk_tot - b0, 0);
      chk("R3 no reset on short pulse", rst_tot - r0, 0);
    end else begin
      chk("R4 blank cycles", blk_tot - b0, p - B);
      chk("R4 blank offset", last_blk_off, B);
      chk("R5 one reset request", rst_tot - r0, 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int l0, b0, r0;
    ctl = 1'b1;  // high during reset must not leak
    repeat (3) @(negedge clk);
    chk("R8 latch in reset", int'(latch), 0);
    chk("R8 blank in reset", int'(blank), 0);
    chk("R8 reset_req in reset", int'(rreq), 0);
    ctl = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 idle outputs", int'({latch, blank, rreq}), 0);

    // R1 latency
    ctl = 1'b1;
    @(negedge clk) chk("R1 no latch after one edge", int'(latch), 0);
    @(negedge clk) chk("R1 latch after two edges", int'(latch), 1);
    @(negedge clk) chk("R2 latch one cycle", int'(latch), 0);
    ctl = 1'b0;
    repeat (5) @(negedge clk);

    // sweep of pulse lengths and gaps
    for (int g = 1; g <= 3; g++)
      for (int p = 1; p <= B + 6; p++)
        pulse(p, g);

    // R6 saturation on a very long pulse
    blk_gap = 0;
    pulse(B + 300, 2);
    chk("R6 blank without gap", blk_gap, 0);

    // R7 back-to-back long pulses split by one low cycle
    l0 = lat_tot; b0 = blk_tot; r0 = rst_tot;
    @(negedge clk) ctl = 1'b1;
    repeat (B + 3) @(negedge clk);
    ctl = 1'b0;
    @(negedge clk) ctl = 1'b1;
    repeat (B + 2) @(negedge clk);
    ctl = 1'b0;
    repeat (6) @(negedge clk);
    chk("R7 two latches", lat_tot - l0, 2);
    chk("R7 blank cycles", blk_tot - b0, 3 + 2);
    chk("R7 two reset requests", rst_tot - r0, 2);
    chk("R7 second blank offset", last_blk_off, B);

    // R3 pulse at the latch limit
    pulse(L, 2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule